// File: doc/BRIEF.md
# Grouped Priority Interrupt Arbiter

This block gathers up to 32 interrupt requests from peripherals and external pins. Each source has its own configuration inputs: an enable, a 4-bit priority level and a 2-bit group number. Level and group together give 64 ranks. A peripheral event pulse sets a pending flag for its source. The arbiter picks the single highest-ranked pending source that is allowed to interrupt. It then compares that source's level with the CPU's current run-time priority.

A source that passes the comparison is granted on one of two paths. Sources at the two top levels go to a data-transfer engine when the transfer channel they map to still has a nonzero data count. All other accepted sources go to the CPU as a normal service request. A normal service request carries the source index as vector and the source's level as the new CPU priority.

The grant is registered and held until the consumer acknowledges it. The acknowledge clears the winning source's pending flag, and the next arbitration round starts in the following cycle.

Top module: `irq_arbiter`

## Requirements
- R1: After reset all pending flags are clear and neither `svc_req` nor `xfer_req` is asserted.
- R2: A one-cycle `irq_pulse[i]` sets source i's pending flag. The flag stays set until a grant of source i is acknowledged. A pulse for source i in the same cycle as that acknowledge leaves the flag set.
- R3: A pending source is eligible only if it is enabled and its level is strictly greater than `cpu_prio`. A level-0 source is therefore never granted.
- R4: Among eligible sources, the one with the higher level wins. At equal level, the higher group number wins.
- R5: When eligible sources share both level and group, the one with the lower index wins.
- R6: A grant is registered one clock edge after the winning flag is visible. The grant is held until `ack` is sampled high. After an acknowledged grant the request outputs are low for exactly one cycle before the next grant.
- R7: A winner at level 14 or 15 whose channel bit `xfer_cnt_nz[ch]` is 1 raises only `xfer_req`, with `xfer_chan` = ch = (level-14)*4 + group.
- R8: Every other winner raises only `svc_req`, with `svc_vec` = source index and `svc_prio` = source level. This includes a level-14/15 winner whose channel bit is 0.
- R9: While a grant is held, changes to `cpu_prio`, the source configuration or `xfer_cnt_nz` do not change the request outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pulse | input | 32 | Per-source event pulse, sets the pending flag |
| src_en | input | 32 | Per-source enable |
| src_lvl | input | 128 | Per-source level, source i at bits [4i+3:4i] |
| src_grp | input | 64 | Per-source group, source i at bits [2i+1:2i] |
| cpu_prio | input | 4 | CPU run-time priority |
| xfer_cnt_nz | input | 8 | Per-channel nonzero-count flag of the transfer engine |
| ack | input | 1 | Acknowledge of the held grant |
| svc_req | output | 1 | Normal service request |
| svc_vec | output | 5 | Vector index (winning source) |
| svc_prio | output | 4 | New CPU priority |
| xfer_req | output | 1 | Data-transfer request |
| xfer_chan | output | 3 | Transfer channel index |

## Verification
Directed patterns separate the orderings. One pattern has different levels, one has equal levels with different groups, and one has identical level/group pairs, so a level-first, group-second and lowest-index-last ordering each show up alone. Threshold patterns set `cpu_prio` equal to and one below a source level, and also try a level-0 source. Together they show that the comparison is strict. Top-level sources are tried with their channel bit set and cleared, which tells the two routing paths apart and checks the channel formula. Random configurations, with many simultaneous pulses and a random CPU priority, drain every pending source one grant at a time. Each grant order is compared with a reference ranking, and these runs also exercise the hold and the one-cycle gap between grants.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W = 4;
  localparam int GRP_W = 2;
  localparam int CH_W  = 1 + GRP_W;
  localparam int NCH   = 1 << CH_W;

  typedef struct packed {
    logic [LVL_W-1:0] lvl;
    logic [GRP_W-1:0] grp;
  } rank_t;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] flag_o
);
  logic [NSRC-1:0] flag_q, flag_d;

  // a set arriving with a clear wins
  always_comb flag_d = (flag_q & ~clr_i) | set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R2: an uncleared flag never drops
  a_r2_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(flag_q & ~clr_i)) == $past(flag_q & ~clr_i)));
  // R2: a pulse always leaves its flag set
  a_r2_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/irq_rank_pick.sv
module irq_rank_pick
  import irq_arb_pkg::*;
#(
  parameter int NSRC = 32,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]       flag_i,
  input  logic [NSRC-1:0]       en_i,
  input  logic [NSRC*LVL_W-1:0] lvl_i,
  input  logic [NSRC*GRP_W-1:0] grp_i,
  input  logic [LVL_W-1:0]      cpu_prio_i,
  output logic                  hit_o,
  output logic [IDX_W-1:0]      idx_o,
  output rank_t                 rank_o
);
  logic [NSRC-1:0] elig;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_elig
      assign elig[i] = flag_i[i] & en_i[i] & (lvl_i[i*LVL_W +: LVL_W] > cpu_prio_i);
    end
  endgenerate

  // scan from the top index down; ">=" lets a lower index take an equal rank
  always_comb begin
    hit_o  = 1'b0;
    idx_o  = '0;
    rank_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i] && (!hit_o ||
          {lvl_i[i*LVL_W +: LVL_W], grp_i[i*GRP_W +: GRP_W]} >= rank_o)) begin
        hit_o  = 1'b1;
        idx_o  = IDX_W'(i);
        rank_o = {lvl_i[i*LVL_W +: LVL_W], grp_i[i*GRP_W +: GRP_W]};
      end
    end
  end
endmodule

// File: rtl/irq_grant_reg.sv
module irq_grant_reg
  import irq_arb_pkg::*;
#(
  parameter int NSRC = 32,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_i,
  input  logic [IDX_W-1:0] idx_i,
  input  rank_t            rank_i,
  input  logic [LVL_W-1:0] cpu_prio_i,
  input  logic [NCH-1:0]   cnt_nz_i,
  input  logic             ack_i,
  output logic             vld_o,
  output logic             xfer_o,
  output logic [IDX_W-1:0] idx_o,
  output rank_t            rank_o
);
  logic             vld_q, vld_d;
  logic             xfer_q, xfer_d;
  logic [IDX_W-1:0] idx_q;
  rank_t            rank_q;
  logic             load;
  logic [CH_W-1:0]  ch;

  assign ch   = {rank_i.lvl[0], rank_i.grp};
  assign load = ~vld_q & hit_i;

  always_comb begin
    vld_d  = vld_q;
    xfer_d = (rank_i.lvl[LVL_W-1:1] == '1) & cnt_nz_i[ch];
    if (vld_q && ack_i) vld_d = 1'b0;
    else if (load)      vld_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_q <= 1'b0;
      idx_q  <= '0;
      rank_q <= '0;
    end else if (load) begin
      xfer_q <= xfer_d;
      idx_q  <= idx_i;
      rank_q <= rank_i;
    end
  end

  assign vld_o  = vld_q;
  assign xfer_o = xfer_q;
  assign idx_o  = idx_q;
  assign rank_o = rank_q;

  // R6, R9: an unacknowledged grant keeps its content
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q && !ack_i |=> vld_q && $stable(idx_q) && $stable(rank_q) && $stable(xfer_q));
  // R6: acknowledge frees the grant for one cycle
  a_r6_drop: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q && ack_i |=> !vld_q);
  // R3: a new grant outranks the CPU priority seen when it was taken
  a_r3_above_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_q) |-> rank_q.lvl > $past(cpu_prio_i));
  // R7: transfer path only for the two top levels
  a_r7_top_only: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q && xfer_q |-> rank_q.lvl >= 4'd14);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NSRC = 32,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       irq_pulse,
  input  logic [NSRC-1:0]       src_en,
  input  logic [NSRC*LVL_W-1:0] src_lvl,
  input  logic [NSRC*GRP_W-1:0] src_grp,
  input  logic [LVL_W-1:0]      cpu_prio,
  input  logic [NCH-1:0]        xfer_cnt_nz,
  input  logic                  ack,
  output logic                  svc_req,
  output logic [IDX_W-1:0]      svc_vec,
  output logic [LVL_W-1:0]      svc_prio,
  output logic                  xfer_req,
  output logic [CH_W-1:0]       xfer_chan
);
  logic [NSRC-1:0]  flag, clr;
  logic             hit, g_vld, g_xfer;
  logic [IDX_W-1:0] p_idx, g_idx;
  rank_t            p_rank, g_rank;

  assign clr = (ack && g_vld) ? (NSRC'(1) << g_idx) : '0;

  irq_flag_bank #(.NSRC(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(irq_pulse), .clr_i(clr), .flag_o(flag));

  irq_rank_pick #(.NSRC(NSRC)) u_pick (
    .flag_i(flag), .en_i(src_en), .lvl_i(src_lvl), .grp_i(src_grp),
    .cpu_prio_i(cpu_prio), .hit_o(hit), .idx_o(p_idx), .rank_o(p_rank));

  irq_grant_reg #(.NSRC(NSRC)) u_grant (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .idx_i(p_idx), .rank_i(p_rank),
    .cpu_prio_i(cpu_prio), .cnt_nz_i(xfer_cnt_nz), .ack_i(ack),
    .vld_o(g_vld), .xfer_o(g_xfer), .idx_o(g_idx), .rank_o(g_rank));

  assign svc_req   = g_vld & ~g_xfer;
  assign xfer_req  = g_vld &  g_xfer;
  assign svc_vec   = g_idx;
  assign svc_prio  = g_rank.lvl;
  assign xfer_chan = {g_rank.lvl[0], g_rank.grp};

  // R8: a granted service never picks a source whose flag is clear
  a_r8_flag_behind: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> flag[svc_vec]);
endmodule

// File: tb/irq_arbiter_test.sv
module irq_arbiter_test;
  localparam int NSRC = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   irq_pulse = '0;
  logic [31:0]   src_en = '0;
  logic [127:0]  src_lvl = '0;
  logic [63:0]   src_grp = '0;
  logic [3:0]    cpu_prio = 4'd15;
  logic [7:0]    xfer_cnt_nz = '0;
  logic          ack = 1'b0;
  logic          svc_req, xfer_req;
  logic [4:0]    svc_vec;
  logic [3:0]    svc_prio;
  logic [2:0]    xfer_chan;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] mflag = '0;

  always #5 clk = ~clk;

  irq_arbiter uut (
    .clk(clk), .rst_n(rst_n), .irq_pulse(irq_pulse), .src_en(src_en),
    .src_lvl(src_lvl), .src_grp(src_grp), .cpu_prio(cpu_prio),
    .xfer_cnt_nz(xfer_cnt_nz), .ack(ack), .svc_req(svc_req),
    .svc_vec(svc_vec), .svc_prio(svc_prio), .xfer_req(xfer_req),
    .xfer_chan(xfer_chan));

  function automatic int ref_pick();
    int best = -1;
    int bkey = -1;
    for (int i = 0; i < NSRC; i++) begin
      int lv = int'(src_lvl[i*4 +: 4]);
      int key = lv * 4 + int'(src_grp[i*2 +: 2]);
      if (mflag[i] && src_en[i] && lv > int'(cpu_prio) && key > bkey) begin
        best = i;
        bkey = key;
      end
    end
    return best;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_none(input string tag);
    chk(!svc_req, tag, int'(svc_req), 0);
    chk(!xfer_req, tag, int'(xfer_req), 0);
  endtask

  // compare outputs against the reference winner; returns it
  task automatic expect_winner(input string tag, output int w);
    int lv, ch;
    bit xf;
    w = ref_pick();
    if (w < 0) begin
      expect_none(tag);
      return;
    end
    lv = int'(src_lvl[w*4 +: 4]);
    ch = (lv - 14) * 4 + int'(src_grp[w*2 +: 2]);
    xf = (lv >= 14) && xfer_cnt_nz[ch & 7];
    if (xf) begin
      chk(xfer_req && !svc_req, {tag, " R7 path"}, int'(xfer_req), 1);
      chk(int'(xfer_chan) == ch, {tag, " R7 chan"}, int'(xfer_chan), ch);
    end else begin
      chk(svc_req && !xfer_req, {tag, " R8 path"}, int'(svc_req), 1);
      chk(int'(svc_vec) == w, {tag, " R8 vec"}, int'(svc_vec), w);
      chk(int'(svc_prio) == lv, {tag, " R8 prio"}, int'(svc_prio), lv);
    end
  endtask

  // entry: at negedge, flags settled one edge ago, no grant held
  task automatic serve(input string tag);
    int w;
    step();
    for (int k = 0; k < NSRC + 2; k++) begin
      expect_winner(tag, w);
      if (w < 0) return;
      ack = 1'b1;
      mflag[w] = 1'b0;
      step();
      ack = 1'b0;
      expect_none({tag, " R6 gap"});
      step();
    end
  endtask

  task automatic pulse_then_serve(input logic [31:0] m, input logic [3:0] cp,
                                  input string tag);
    irq_pulse = m;
    mflag = mflag | m;
    step();
    irq_pulse = '0;
    cpu_prio = cp;
    serve(tag);
  endtask

  task automatic set_src(input int i, input bit e, input int lv, input int g);
    src_en[i] = e;
    src_lvl[i*4 +: 4] = 4'(lv);
    src_grp[i*2 +: 2] = 2'(g);
  endtask

  task automatic clear_cfg();
    cpu_prio = 4'd15;
    src_en = '0;
    src_lvl = '0;
    src_grp = '0;
    xfer_cnt_nz = '0;
  endtask

  initial begin
    #(200000 * 10);
    n_err++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    int w;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_none("R1 reset");

    // R6 latency: pulse at edge P0, nothing after P0, grant after P1
    set_src(4, 1, 5, 1);
    cpu_prio = 4'd0;
    irq_pulse = 32'h10;
    mflag = 32'h10;
    step();
    irq_pulse = '0;
    expect_none("R6 latency early");
    step();
    expect_winner("R6 latency grant", w);
    ack = 1'b1; mflag[4] = 1'b0; step(); ack = 1'b0;
    expect_none("R6 after ack");
    step();
    expect_none("R2 flag cleared");

    // R3: level 0 never; equal priority blocked; one below accepted
    clear_cfg();
    set_src(3, 1, 0, 3);
    set_src(4, 1, 5, 0);
    set_src(8, 0, 9, 0);
    pulse_then_serve(32'h118, 4'd5, "R3 equal blocked");
    cpu_prio = 4'd15; step();
    cpu_prio = 4'd0; step();
    chk(svc_req && svc_vec == 5'd4, "R3 level0 and disabled skipped",
        int'(svc_vec), 4);
    ack = 1'b1; mflag[4] = 1'b0; step(); ack = 1'b0; step();
    expect_none("R3 level0 never granted");
    cpu_prio = 4'd15; step();

    // R4, R5 ordering
    clear_cfg();
    mflag = '0;
    set_src(1, 1, 9, 1);
    set_src(2, 1, 9, 3);
    set_src(7, 1, 11, 0);
    set_src(9, 1, 9, 3);
    step();
    // flags 3 and 8 from earlier still pending but disabled in model and RTL
    mflag = 32'h108;
    pulse_then_serve(32'h286, 4'd2, "R4 R5 order");

    // R7 / R8 routing
    clear_cfg();
    set_src(5, 1, 15, 2);
    set_src(6, 1, 14, 1);
    set_src(10, 1, 14, 3);
    xfer_cnt_nz = 8'b0100_1000;
    pulse_then_serve(32'h460, 4'd3, "R7 R8 route");

    // R9: grant frozen against input changes
    clear_cfg();
    set_src(12, 1, 7, 2);
    irq_pulse = 32'h1000; mflag[12] = 1'b1; step(); irq_pulse = '0;
    cpu_prio = 4'd1; step();
    expect_winner("R9 initial", w);
    cpu_prio = 4'd15;
    src_en = '0;
    src_lvl[12*4 +: 4] = 4'd2;
    xfer_cnt_nz = 8'hff;
    step(); step();
    chk(svc_req && svc_vec == 5'd12 && svc_prio == 4'd7, "R9 held",
        int'(svc_prio), 7);
    ack = 1'b1; mflag[12] = 1'b0; step(); ack = 1'b0; step();
    expect_none("R9 released");

    // R2: pulse coincident with acknowledge keeps the flag
    clear_cfg();
    set_src(0, 1, 3, 0);
    irq_pulse = 32'h1; mflag[0] = 1'b1; step(); irq_pulse = '0;
    cpu_prio = 4'd0; step();
    expect_winner("R2 first", w);
    ack = 1'b1; irq_pulse = 32'h1; step();
    ack = 1'b0; irq_pulse = '0;
    expect_none("R2 gap");
    step();
    chk(svc_req && svc_vec == 5'd0, "R2 retained flag", int'(svc_req), 1);
    ack = 1'b1; mflag[0] = 1'b0; step(); ack = 1'b0; step(); step();
    expect_none("R2 drained");

    // random configurations
    for (int r = 0; r < 300; r++) begin
      logic [31:0] m;
      cpu_prio = 4'd15;
      for (int i = 0; i < NSRC; i++)
        set_src(i, ($urandom % 10) < 7, int'($urandom % 16), int'($urandom % 4));
      xfer_cnt_nz = 8'($urandom);
      m = $urandom & $urandom;
      pulse_then_serve(m, 4'($urandom % 9), "R4 R7 R8 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule